// File: doc/BRIEF.md
# DDR Clock-Enable Power-State Sequencer

This block sits on the controller side of a DDR SDRAM interface. It owns the clock-enable pin and, while the memory is in or near a low-power state, it also owns the command bus. Upstream logic asks for power-down, self-refresh or wake-up with single-cycle request pulses. The block also sees a per-bank open-row vector and a busy flag that marks an access in flight. From these it chooses and sequences the transitions. At entry it picks precharge or active power-down from the bank state sampled on the entry edge. During power-down it drives the idle command codes. After exit it holds the command bus on NOP for a guard window before it hands the bus back.

Exits are gated by the state being left. Leaving power-down costs a short guard of one cycle plus the input setup time rounded to cycles. Leaving self-refresh opens a long NOP-only window so the memory's delay-locked loop can relock. Power-down also has an upper limit: a dwell counter forces an exit before the refresh deadline. A request that arrives while the bus is not ready is held and served once the block returns to normal operation. If upstream tries to issue a command while the bus is not ready, the block raises a sticky error flag that only reset clears.

Top module: `cke_power_sequencer`

## Requirements
- R1: After reset the outputs are: cke=1, cmdCode=0 (pass-through), pwrState=0 (normal), ready=1, seqError=0.
- R2: Power-down entry drops cke with cmdCode=1 (NOP) in the first low cycle. In every later low cycle cmdCode=2 (DESELECT). pwrState=1 (precharge power-down) when bankActive was all zero at the entry edge, and pwrState=2 (active power-down) otherwise.
- R3: While accessBusy is high, a pending power-down or self-refresh request does not enter. It enters on the first edge after accessBusy falls.
- R4: cke stays low for at least MIN_LOW = 1+TIS_CYC cycles, even when wakeReq arrives earlier.
- R5: Once the minimum is met, cke rises in the cycle after wakeReq is sampled, with cmdCode=1. After a power-down exit, ready stays low, with cmdCode=1, for exactly 1+TIS_CYC cycles counted from the first cycle with cke high.
- R6: Self-refresh entry drops cke with cmdCode=3 (AUTO REFRESH) and pwrState=3. It happens only when bankActive is all zero; otherwise the request waits. When power-down and self-refresh are both pending, self-refresh is served first.
- R7: After a self-refresh exit, ready stays low, with cmdCode=1, for exactly SR_EXIT_CYC cycles from the first cycle with cke high.
- R8: Without a wake request, power-down ends on its own after exactly PD_MAX_CYC cycles with cke low.
- R9: A power-down or self-refresh request pulsed while ready is low is held. It is served after ready returns.
- R10: wakeReq while pwrState=0 and ready=1 has no effect: cke and ready stay high.
- R11: hostCmdValid while ready is low sets seqError on the next edge. seqError then stays high until reset.
- R12: Whenever ready is high, cke is high and pwrState=0. Whenever cke is low, cmdCode is never 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| pdReq | input | 1 | Power-down request pulse |
| srReq | input | 1 | Self-refresh request pulse |
| wakeReq | input | 1 | Wake request pulse |
| accessBusy | input | 1 | High while an access is in progress |
| bankActive | input | NUM_BANKS | One bit per bank, high when a row is open |
| hostCmdValid | input | 1 | Upstream is presenting an executable command |
| cke | output | 1 | Clock-enable to the memory |
| cmdCode | output | 2 | 0 pass-through, 1 NOP, 2 DESELECT, 3 AUTO REFRESH |
| pwrState | output | 2 | 0 normal, 1 precharge power-down, 2 active power-down, 3 self refresh |
| ready | output | 1 | Executable commands may be issued |
| seqError | output | 1 | Sticky illegal-sequence flag |

## Verification
The assertions check the cycle-local rules on every cycle. They cover the entry command and power-down type against the banks on the entry edge, the minimum and maximum cke-low run measured by a checker counter, NOP on the rising edge of cke, and the idle-bank condition for self-refresh. They also cover the blocking effect of the busy flag, the consistency between ready and cke, and the stickiness of the error flag. Only the bench scenarios can show the exact guard lengths and wake latency. The same holds for requests that are held through a low-power period and served later, the priority between two pending requests, and the fact that a wake pulse in normal operation does nothing.

// File: rtl/cke_seq_pkg.sv
package cke_seq_pkg;

  typedef enum logic [1:0] {
    CMD_PASS  = 2'd0,
    CMD_NOP   = 2'd1,
    CMD_DESEL = 2'd2,
    CMD_AREF  = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    PWR_NORMAL   = 2'd0,
    PWR_PRE_PD   = 2'd1,
    PWR_ACT_PD   = 2'd2,
    PWR_SELF_REF = 2'd3
  } pwr_e;

  typedef enum logic [2:0] {
    SQ_RUN,
    SQ_PRE_PD,
    SQ_ACT_PD,
    SQ_SREF,
    SQ_PD_EXIT,
    SQ_SR_EXIT
  } seq_e;

  // control -> datapath strobes
  typedef struct packed {
    logic dwellLoad;
    logic dwellInc;
    logic guardLoadPd;
    logic guardLoadSr;
    logic guardDec;
    logic pdTake;
    logic srTake;
    logic wakeTake;
    logic wakeArm;
  } seq_strobe_t;

  // datapath -> control status
  typedef struct packed {
    logic pdSeen;
    logic srSeen;
    logic wakeSeen;
    logic minMet;
    logic deadline;
    logic guardLast;
  } seq_status_t;

endpackage

// File: rtl/cke_seq_datapath.sv
module cke_seq_datapath
  import cke_seq_pkg::*;
#(
  parameter int MIN_LOW    = 2,
  parameter int PD_MAX_CYC = 64,
  parameter int PD_GUARD   = 2,
  parameter int SR_GUARD   = 200
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pdReq,
  input  logic        srReq,
  input  logic        wakeReq,
  input  seq_strobe_t stb,
  output seq_status_t sts
);

  localparam int DW   = $clog2(PD_MAX_CYC + 1);
  localparam int GMAX = (SR_GUARD > PD_GUARD) ? SR_GUARD : PD_GUARD;
  localparam int GW   = $clog2(GMAX + 1);
  localparam logic [DW-1:0] MIN_V   = DW'(MIN_LOW);
  localparam logic [DW-1:0] MAX_V   = DW'(PD_MAX_CYC);
  localparam logic [GW-1:0] PDG_V   = GW'(PD_GUARD);
  localparam logic [GW-1:0] SRG_V   = GW'(SR_GUARD);
  localparam logic [GW-1:0] ONE_G   = GW'(1);

  logic          pdPend, srPend, wakePend;
  logic [DW-1:0] dwell;
  logic [GW-1:0] guard;

  // held requests: set by a pulse, cleared only when the control consumes them
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pdPend   <= 1'b0;
      srPend   <= 1'b0;
      wakePend <= 1'b0;
    end else begin
      pdPend   <= (pdPend | pdReq) & ~stb.pdTake;
      srPend   <= (srPend | srReq) & ~stb.srTake;
      wakePend <= stb.wakeArm & ~stb.wakeTake & (wakePend | wakeReq);
    end
  end

  // cycles spent with the clock enable low, saturating at the power-down limit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dwell <= '0;
    end else if (stb.dwellLoad) begin
      dwell <= DW'(1);
    end else if (stb.dwellInc && dwell != MAX_V) begin
      dwell <= dwell + DW'(1);
    end
  end

  // exit guard down-counter, length picked by the state being left
  always_ff @(posedge clk) begin
    if (!rstN) begin
      guard <= '0;
    end else if (stb.guardLoadPd) begin
      guard <= PDG_V;
    end else if (stb.guardLoadSr) begin
      guard <= SRG_V;
    end else if (stb.guardDec && guard != '0) begin
      guard <= guard - ONE_G;
    end
  end

  always_comb begin
    sts.pdSeen    = pdPend | pdReq;
    sts.srSeen    = srPend | srReq;
    sts.wakeSeen  = wakePend | (wakeReq & stb.wakeArm);
    sts.minMet    = (dwell >= MIN_V);
    sts.deadline  = (dwell >= MAX_V);
    sts.guardLast = (guard <= ONE_G);
  end

endmodule

// File: rtl/cke_seq_control.sv
module cke_seq_control
  import cke_seq_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 accessBusy,
  input  logic [NUM_BANKS-1:0] bankActive,
  input  logic                 hostCmdValid,
  input  seq_status_t          sts,
  output seq_strobe_t          stb,
  output logic                 cke,
  output cmd_e                 cmdCode,
  output pwr_e                 pwrState,
  output logic                 ready,
  output logic                 seqError
);

  seq_e st, stNext;
  logic ckeNext;
  cmd_e cmdNext;
  logic banksIdle;

  assign banksIdle = ~|bankActive;

  always_comb begin
    stNext  = st;
    ckeNext = 1'b1;
    cmdNext = CMD_NOP;
    stb     = '0;
    unique case (st)
      SQ_RUN: begin
        cmdNext = CMD_PASS;
        if (sts.srSeen && !accessBusy && banksIdle) begin
          stNext        = SQ_SREF;
          ckeNext       = 1'b0;
          cmdNext       = CMD_AREF;
          stb.dwellLoad = 1'b1;
          stb.srTake    = 1'b1;
        end else if (sts.pdSeen && !accessBusy) begin
          stNext        = banksIdle ? SQ_PRE_PD : SQ_ACT_PD;
          ckeNext       = 1'b0;
          cmdNext       = CMD_NOP;
          stb.dwellLoad = 1'b1;
          stb.pdTake    = 1'b1;
        end
      end
      SQ_PRE_PD, SQ_ACT_PD: begin
        stb.wakeArm = 1'b1;
        if (sts.minMet && (sts.wakeSeen || sts.deadline)) begin
          stNext          = SQ_PD_EXIT;
          stb.guardLoadPd = 1'b1;
          stb.wakeTake    = 1'b1;
        end else begin
          ckeNext      = 1'b0;
          cmdNext      = CMD_DESEL;
          stb.dwellInc = 1'b1;
        end
      end
      SQ_SREF: begin
        stb.wakeArm = 1'b1;
        if (sts.minMet && sts.wakeSeen) begin
          stNext          = SQ_SR_EXIT;
          stb.guardLoadSr = 1'b1;
          stb.wakeTake    = 1'b1;
        end else begin
          ckeNext      = 1'b0;
          cmdNext      = CMD_DESEL;
          stb.dwellInc = 1'b1;
        end
      end
      SQ_PD_EXIT, SQ_SR_EXIT: begin
        stb.guardDec = 1'b1;
        if (sts.guardLast) begin
          stNext  = SQ_RUN;
          cmdNext = CMD_PASS;
        end
      end
      default: stNext = SQ_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= SQ_RUN;
      cke      <= 1'b1;
      cmdCode  <= CMD_PASS;
      seqError <= 1'b0;
    end else begin
      st       <= stNext;
      cke      <= ckeNext;
      cmdCode  <= cmdNext;
      seqError <= seqError | (hostCmdValid & ~ready);
    end
  end

  always_comb begin
    unique case (st)
      SQ_PRE_PD: pwrState = PWR_PRE_PD;
      SQ_ACT_PD: pwrState = PWR_ACT_PD;
      SQ_SREF:   pwrState = PWR_SELF_REF;
      default:   pwrState = PWR_NORMAL;
    endcase
  end

  assign ready = (st == SQ_RUN);

endmodule

// File: rtl/cke_power_sequencer.sv
module cke_power_sequencer
  import cke_seq_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int TIS_CYC     = 1,
  parameter int PD_MAX_CYC  = 64,
  parameter int SR_EXIT_CYC = 200
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pdReq,
  input  logic                 srReq,
  input  logic                 wakeReq,
  input  logic                 accessBusy,
  input  logic [NUM_BANKS-1:0] bankActive,
  input  logic                 hostCmdValid,
  output logic                 cke,
  output logic [1:0]           cmdCode,
  output logic [1:0]           pwrState,
  output logic                 ready,
  output logic                 seqError
);

  localparam int MIN_LOW  = 1 + TIS_CYC;
  localparam int PD_GUARD = 1 + TIS_CYC;

  seq_strobe_t stb;
  seq_status_t sts;
  cmd_e        cmdInt;
  pwr_e        pwrInt;

  cke_seq_datapath #(
    .MIN_LOW   (MIN_LOW),
    .PD_MAX_CYC(PD_MAX_CYC),
    .PD_GUARD  (PD_GUARD),
    .SR_GUARD  (SR_EXIT_CYC)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .pdReq  (pdReq),
    .srReq  (srReq),
    .wakeReq(wakeReq),
    .stb    (stb),
    .sts    (sts)
  );

  cke_seq_control #(
    .NUM_BANKS(NUM_BANKS)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .accessBusy  (accessBusy),
    .bankActive  (bankActive),
    .hostCmdValid(hostCmdValid),
    .sts         (sts),
    .stb         (stb),
    .cke         (cke),
    .cmdCode     (cmdInt),
    .pwrState    (pwrInt),
    .ready       (ready),
    .seqError    (seqError)
  );

  assign cmdCode  = cmdInt;
  assign pwrState = pwrInt;

endmodule

// File: rtl/cke_power_sequencer_chk.sv
module cke_power_sequencer_chk #(
  parameter int NUM_BANKS  = 4,
  parameter int TIS_CYC    = 1,
  parameter int PD_MAX_CYC = 64
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 accessBusy,
  input logic [NUM_BANKS-1:0] bankActive,
  input logic                 hostCmdValid,
  input logic                 cke,
  input logic [1:0]           cmdCode,
  input logic [1:0]           pwrState,
  input logic                 ready,
  input logic                 seqError
);

  localparam int MIN_LOW = 1 + TIS_CYC;

  logic [15:0] lowRun;

  always_ff @(posedge clk) begin
    if (!rstN)            lowRun <= '0;
    else if (cke)         lowRun <= '0;
    else if (lowRun != 16'hFFFF) lowRun <= lowRun + 16'd1;
  end

  AST_PD_TYPE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cke) && cmdCode == 2'd1 |-> pwrState == ($past(|bankActive) ? 2'd2 : 2'd1)); // R2
  AST_NO_ENTRY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cke) |-> !$past(accessBusy)); // R3
  AST_MIN_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cke) |-> lowRun >= 16'(MIN_LOW)); // R4
  AST_EXIT_NOP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cke) |-> cmdCode == 2'd1 && !ready); // R5
  AST_SR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    cmdCode == 2'd3 |-> !cke && pwrState == 2'd3 && $past(bankActive) == '0); // R6
  AST_PD_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cke) && $past(pwrState) != 2'd3 |-> lowRun <= 16'(PD_MAX_CYC)); // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    seqError |=> seqError); // R11
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(seqError) |-> $past(hostCmdValid && !ready)); // R11
  AST_READY_CKE: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> cke && pwrState == 2'd0); // R12
  AST_LOW_NO_PASS: assert property (@(posedge clk) disable iff (!rstN)
    !cke |-> cmdCode != 2'd0); // R12

endmodule

bind cke_power_sequencer cke_power_sequencer_chk #(
  .NUM_BANKS (NUM_BANKS),
  .TIS_CYC   (TIS_CYC),
  .PD_MAX_CYC(PD_MAX_CYC)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .accessBusy  (accessBusy),
  .bankActive  (bankActive),
  .hostCmdValid(hostCmdValid),
  .cke         (cke),
  .cmdCode     (cmdCode),
  .pwrState    (pwrState),
  .ready       (ready),
  .seqError    (seqError)
);

// File: tb/cke_power_sequencer_bench.sv
`timescale 1ns/1ps
module cke_power_sequencer_bench;

  localparam int NB     = 4;
  localparam int PDMAX  = 64;
  localparam int SRREC  = 200;
  localparam int MINL   = 2;
  localparam int GUARD  = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pdReq = 1'b0, srReq = 1'b0, wakeReq = 1'b0, accessBusy = 1'b0, hostCmdValid = 1'b0;
  logic [NB-1:0] bankActive = '0;
  logic cke, ready, seqError;
  logic [1:0] cmdCode, pwrState;

  always #2 clk = ~clk;

  cke_power_sequencer #(
    .NUM_BANKS(NB), .TIS_CYC(1), .PD_MAX_CYC(PDMAX), .SR_EXIT_CYC(SRREC)
  ) u_cke_power_sequencer (
    .clk(clk), .rstN(rstN), .pdReq(pdReq), .srReq(srReq), .wakeReq(wakeReq),
    .accessBusy(accessBusy), .bankActive(bankActive), .hostCmdValid(hostCmdValid),
    .cke(cke), .cmdCode(cmdCode), .pwrState(pwrState), .ready(ready), .seqError(seqError)
  );

  typedef struct {
    int    kind;   // 0 entry (a=pwrState,b=cmd), 1 exit (a=low cycles,b=cmd), 2 ready (a=guard cycles)
    int    a;
    int    b;
    string req;
  } ev_t;

  ev_t expQ[$];
  int  nCmp = 0;
  int  nBad = 0;
  int  lowCnt = 0, guardCnt = 0;
  logic prevCke = 1'b1, prevReady = 1'b1;

  task automatic pushEv(input int kind, input int a, input int b, input string req);
    ev_t e;
    e.kind = kind; e.a = a; e.b = b; e.req = req;
    expQ.push_back(e);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int maxi(input int x, input int y);
    return (x > y) ? x : y;
  endfunction

  task automatic observe(input int kind, input int a, input int b);
    ev_t e;
    nCmp++;
    if (expQ.size() == 0) begin
      nBad++;
      $display("FAIL unexpected event kind %0d: actual %0d/%0d expected none", kind, a, b);
    end else begin
      e = expQ.pop_front();
      if (e.kind != kind || e.a != a || e.b != b) begin
        nBad++;
        $display("FAIL %s: actual kind %0d %0d/%0d expected kind %0d %0d/%0d",
                 e.req, kind, a, b, e.kind, e.a, e.b);
      end
    end
  endtask

  // monitor: turns port activity into events and compares them with the queue
  always @(negedge clk) begin
    if (rstN) begin
      if (prevCke && !cke) begin
        observe(0, int'(pwrState), int'(cmdCode));
        lowCnt = 1;
      end else if (!cke) begin
        lowCnt++;
      end
      if (!prevCke && cke) begin
        observe(1, lowCnt, int'(cmdCode));
        guardCnt = 1;
      end else if (cke && !ready) begin
        guardCnt++;
      end
      if (!prevReady && ready) observe(2, guardCnt, 0);
      prevCke   = cke;
      prevReady = ready;
    end
  end

  // called at the negedge before the entry edge; K = cycles low before wake is driven
  task automatic lowPhase(input int K);
    @(negedge clk);
    pdReq = 1'b0; srReq = 1'b0;
    check(!ready && cmdCode != 2'd0, "R12 low cycle not ready", int'(cmdCode), 1);
    for (int i = 1; i < K; i++) begin
      @(negedge clk);
      if (i == 1) check(cmdCode == 2'd2, "R2 deselect while low", int'(cmdCode), 2);
    end
    wakeReq = 1'b1;
    @(negedge clk);
    wakeReq = 1'b0;
    wait (ready == 1'b1);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    nCmp++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    check(cke == 1'b1, "R1 cke", cke, 1);
    check(cmdCode == 2'd0, "R1 cmd", cmdCode, 0);
    check(pwrState == 2'd0, "R1 state", pwrState, 0);
    check(ready == 1'b1, "R1 ready", ready, 1);
    check(seqError == 1'b0, "R1 error", seqError, 0);

    // R2 R5: precharge power-down, late wake
    bankActive = '0;
    pushEv(0, 1, 1, "R2 precharge entry");
    pushEv(1, 5, 1, "R5 exit latency");
    pushEv(2, GUARD, 0, "R5 pd guard");
    pdReq = 1'b1;
    lowPhase(5);

    // R2 R4: active power-down, early wake
    bankActive = 4'b0100;
    pushEv(0, 2, 1, "R2 active entry");
    pushEv(1, maxi(1, MINL), 1, "R4 minimum low");
    pushEv(2, GUARD, 0, "R5 pd guard");
    pdReq = 1'b1;
    lowPhase(1);
    bankActive = '0;

    // R8: forced exit at the dwell limit
    pushEv(0, 1, 1, "R8 entry");
    pushEv(1, PDMAX, 1, "R8 forced exit");
    pushEv(2, GUARD, 0, "R8 guard");
    pdReq = 1'b1;
    @(negedge clk);
    pdReq = 1'b0;
    wait (cke == 1'b1);
    wait (ready == 1'b1);
    @(negedge clk);

    // R3: busy defers entry
    accessBusy = 1'b1;
    pdReq = 1'b1;
    @(negedge clk);
    pdReq = 1'b0;
    repeat (3) @(negedge clk);
    check(cke == 1'b1 && ready == 1'b1, "R3 held while busy", cke, 1);
    pushEv(0, 1, 1, "R3 entry after busy");
    pushEv(1, 3, 1, "R3 exit");
    pushEv(2, GUARD, 0, "R3 guard");
    accessBusy = 1'b0;
    lowPhase(3);

    // R6 R7: self-refresh waits for idle banks
    bankActive = 4'b0001;
    srReq = 1'b1;
    @(negedge clk);
    srReq = 1'b0;
    repeat (3) @(negedge clk);
    check(cke == 1'b1 && pwrState == 2'd0, "R6 held while bank open", cke, 1);
    pushEv(0, 3, 3, "R6 self-refresh entry");
    pushEv(1, 4, 1, "R7 sr exit");
    pushEv(2, SRREC, 0, "R7 sr recovery");
    bankActive = '0;
    lowPhase(4);

    // R6 priority, R9 held power-down after self-refresh
    pushEv(0, 3, 3, "R6 priority to self-refresh");
    pushEv(1, 2, 1, "R6 sr exit");
    pushEv(2, SRREC, 0, "R7 sr recovery");
    pushEv(0, 1, 1, "R9 held pd served");
    pushEv(1, 3, 1, "R9 pd exit");
    pushEv(2, GUARD, 0, "R9 pd guard");
    pdReq = 1'b1; srReq = 1'b1;
    lowPhase(2);
    lowPhase(3);

    // R9: self-refresh request pulsed during power-down
    pushEv(0, 1, 1, "R9 pd entry");
    pushEv(1, 2, 1, "R9 pd exit");
    pushEv(2, GUARD, 0, "R9 pd guard");
    pushEv(0, 3, 3, "R9 held sr served");
    pushEv(1, 3, 1, "R9 sr exit");
    pushEv(2, SRREC, 0, "R9 sr recovery");
    pdReq = 1'b1;
    @(negedge clk);
    pdReq = 1'b0;
    srReq = 1'b1;
    @(negedge clk);
    srReq = 1'b0;
    wakeReq = 1'b1;
    @(negedge clk);
    wakeReq = 1'b0;
    wait (ready == 1'b1);
    @(negedge clk);
    lowPhase(3);

    // R10: wake in normal operation
    wakeReq = 1'b1;
    @(negedge clk);
    wakeReq = 1'b0;
    check(cke == 1'b1 && ready == 1'b1, "R10 wake ignored", cke, 1);
    @(negedge clk);
    check(pwrState == 2'd0 && cmdCode == 2'd0, "R10 still normal", pwrState, 0);

    // R11: command while not ready
    check(seqError == 1'b0, "R11 clear before", seqError, 0);
    pushEv(0, 1, 1, "R11 entry");
    pushEv(1, 2, 1, "R11 exit");
    pushEv(2, GUARD, 0, "R11 guard");
    pdReq = 1'b1;
    @(negedge clk);
    pdReq = 1'b0;
    hostCmdValid = 1'b1;
    @(negedge clk);
    hostCmdValid = 1'b0;
    check(seqError == 1'b1, "R11 error raised", seqError, 1);
    wakeReq = 1'b1;
    @(negedge clk);
    wakeReq = 1'b0;
    wait (ready == 1'b1);
    repeat (4) @(negedge clk);
    check(seqError == 1'b1, "R11 error sticky", seqError, 1);

    repeat (5) @(negedge clk);
    check(expQ.size() == 0, "all expected events seen", expQ.size(), 0);
    summary();
    $finish;
  end

endmodule